// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Control Register

This block is the byte-wide control and status register of a two-channel DMA controller. For each channel it stores a run-enable bit and a completion-interrupt-enable bit. It also keeps a global master-enable flag, which is set as a side effect of software turning a channel on. The transfer engines send the block a one-cycle terminal-count pulse when a channel's byte count reaches zero. The block then drops that channel's run-enable.

Software updates the register with a single write strobe and a data byte. A channel's run-enable bit moves only when that channel's write-gate bit in the same byte is 0. This lets one channel be started or stopped without disturbing the other. The gate bits are never stored. The interrupt-enable bits load on every write. Reads are a combinational view of the stored state and have no side effects. Each channel drives a run output (its enable and the master flag both set) and a level interrupt (channel idle while its interrupt is enabled).

Top module: `dma_ctl_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released, both run-enable bits, both interrupt-enable bits and the master flag are 0. The read byte is then 8'h32, and `dma_irq` and `chan_go` are 0.
- R2: On a write with the channel's gate bit at 0, the channel's run-enable loads from the written byte at the next clock edge. The gate bit is bit 4 for channel 0 and bit 5 for channel 1. The enable bit is bit 6 for channel 0 and bit 7 for channel 1.
- R3: On a write with the channel's gate bit at 1, the channel's run-enable keeps its previous value.
- R4: The read byte always shows bits 5, 4 and 1 as 1, whatever was written. It shows the master flag at bit 0, the run-enables at bits 7 and 6, and the interrupt-enables at bits 3 (channel 1) and 2 (channel 0).
- R5: A write that carries a 1 into a channel's enable bit with that channel's gate open sets the master flag at the next edge. This holds even if a terminal count blocks the enable in the same cycle. Only reset clears the master flag. Writing 0 to an enable bit leaves the master flag unchanged.
- R6: A terminal-count pulse on `tc_pulse[i]` clears channel i's run-enable at the next edge. It takes priority over a gated write of 1 to the same channel in the same cycle. A pulse on a channel that is already disabled leaves it at 0.
- R7: Every write loads the interrupt-enable bits from byte bits 3 (channel 1) and 2 (channel 0). No gating applies.
- R8: `dma_irq[i]` is 1 exactly when channel i's run-enable is 0 and its interrupt-enable is 1. The output follows the stored bits in the same cycle.
- R9: `chan_go[i]` is 1 exactly when channel i's run-enable and the master flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, combinational view of the stored state |
| tc_pulse | input | 2 | Per-channel terminal-count pulse from the transfer engines |
| chan_go | output | 2 | Per-channel transfer permission |
| master_en | output | 1 | Global DMA master-enable flag |
| dma_irq | output | 2 | Per-channel completion interrupt request, level |

## Verification
The properties take `reg_wr` and `tc_pulse` as single-cycle, synchronous inputs that are sampled only at the rising edge. The load and hold checks are written for cycles with no terminal count on that channel. A separate property covers the clear that a terminal count causes. The bench changes every input on the falling edge and returns the strobes to 0 soon after each rising edge. Terminal counts that collide with writes appear only in the dedicated priority vectors.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned CSR_W     = 8;
  localparam int unsigned CH_N      = 2;

  // Field positions the CPU decodes
  localparam int unsigned MASTER_BIT = 0;
  localparam int unsigned FILL_BIT   = 1;
  localparam int unsigned IE_BASE    = 2;
  localparam int unsigned GATE_BASE  = 4;
  localparam int unsigned EN_BASE    = 6;

  function automatic int unsigned en_bit(input int unsigned ch);
    return EN_BASE + ch;
  endfunction

  function automatic int unsigned gate_bit(input int unsigned ch);
    return GATE_BASE + ch;
  endfunction

  function automatic int unsigned ie_bit(input int unsigned ch);
    return IE_BASE + ch;
  endfunction

  // A write reaches a channel's enable only with its gate bit at zero
  function automatic logic gate_open(input logic [CSR_W-1:0] w, input int unsigned ch);
    return ~w[gate_bit(ch)];
  endfunction

  // Terminal count wins over software
  function automatic logic next_enable(input logic cur, input logic wr,
                                       input logic [CSR_W-1:0] w,
                                       input int unsigned ch, input logic tc);
    logic nxt;
    nxt = cur;
    if (wr && gate_open(w, ch)) nxt = w[en_bit(ch)];
    if (tc) nxt = 1'b0;
    return nxt;
  endfunction

  function automatic logic irq_level(input logic en, input logic ie);
    return ~en & ie;
  endfunction

endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter int unsigned CH = 0,
  parameter int unsigned W  = CSR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic         tc,
  output logic         en_q,
  output logic         ie_q,
  output logic         arm_req,
  output logic         sw_load
);

  logic en_d;

  assign sw_load = wr_stb & gate_open(wdata, CH);
  assign arm_req = sw_load & wdata[en_bit(CH)];
  assign en_d    = next_enable(en_q, wr_stb, wdata, CH, tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (wr_stb) ie_q <= wdata[ie_bit(CH)];
    end
  end

endmodule

// File: rtl/dma_csr_master.sv
module dma_csr_master #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  output logic         flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (|set_req)  flag_q <= 1'b1;
  end

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
  import dma_csr_pkg::*;
#(
  parameter int unsigned N = CH_N,
  parameter int unsigned W = CSR_W
) (
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] ie_q,
  input  logic         master_q,
  output logic [W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    for (int unsigned c = 0; c < N; c++) begin
      rdata[en_bit(c)]   = en_q[c];
      rdata[gate_bit(c)] = 1'b1;
      rdata[ie_bit(c)]   = ie_q[c];
    end
    rdata[FILL_BIT]   = 1'b1;
    rdata[MASTER_BIT] = master_q;
  end

endmodule

// File: rtl/dma_ctl_status_reg.sv
module dma_ctl_status_reg
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CSR_W-1:0] reg_wdata,
  output logic [CSR_W-1:0] reg_rdata,
  input  logic [CH_N-1:0]  tc_pulse,
  output logic [CH_N-1:0]  chan_go,
  output logic             master_en,
  output logic [CH_N-1:0]  dma_irq
);

  // Named internal events for the checker
  logic [CH_N-1:0] en_q;
  logic [CH_N-1:0] ie_q;
  logic [CH_N-1:0] arm_req;
  logic [CH_N-1:0] sw_load;
  logic            arm_any;

  genvar g;
  generate
    for (g = 0; g < CH_N; g++) begin : g_ch
      dma_csr_chan #(.CH(g), .W(CSR_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (reg_wr),
        .wdata   (reg_wdata),
        .tc      (tc_pulse[g]),
        .en_q    (en_q[g]),
        .ie_q    (ie_q[g]),
        .arm_req (arm_req[g]),
        .sw_load (sw_load[g])
      );
      assign dma_irq[g] = irq_level(en_q[g], ie_q[g]);
      assign chan_go[g] = en_q[g] & master_en;
    end
  endgenerate

  assign arm_any = |arm_req;

  dma_csr_master #(.N(CH_N)) u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (arm_req),
    .flag_q  (master_en)
  );

  dma_csr_rdmux #(.N(CH_N), .W(CSR_W)) u_rdmux (
    .en_q     (en_q),
    .ie_q     (ie_q),
    .master_q (master_en),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [CSR_W-1:0] reg_wdata,
  input logic [CSR_W-1:0] reg_rdata,
  input logic [CH_N-1:0]  tc_pulse,
  input logic [CH_N-1:0]  chan_go,
  input logic             master_en,
  input logic [CH_N-1:0]  dma_irq,
  input logic             arm_any
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (master_en == 1'b0 && chan_go == '0 && dma_irq == '0));

  // R4
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[GATE_BASE+1] && reg_rdata[GATE_BASE] && reg_rdata[FILL_BIT]
    && (reg_rdata[MASTER_BIT] == master_en));

  // R5
  master_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_any |=> master_en);

  // R5
  master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_en |=> master_en);

  // R7
  ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[IE_BASE+1:IE_BASE] == $past(reg_wdata[IE_BASE+1:IE_BASE]));

  genvar i;
  generate
    for (i = 0; i < CH_N; i++) begin : g_ch
      // R2
      gated_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[GATE_BASE+i] && !tc_pulse[i])
        |=> reg_rdata[EN_BASE+i] == $past(reg_wdata[EN_BASE+i]));

      // R3
      gate_closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[GATE_BASE+i] && !tc_pulse[i])
        |=> $stable(reg_rdata[EN_BASE+i]));

      // R6
      tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse[i] |=> !reg_rdata[EN_BASE+i]);

      // R8
      irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq[i] == (!reg_rdata[EN_BASE+i] && reg_rdata[IE_BASE+i]));

      // R9
      go_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_go[i] == (reg_rdata[EN_BASE+i] && master_en));
    end
  endgenerate

endmodule

bind dma_ctl_status_reg dma_csr_chk u_chk (.*);

// File: tb/dma_ctl_status_reg_tb.sv
module dma_ctl_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] tc_pulse = 2'b00;
  logic [1:0] chan_go;
  logic       master_en;
  logic [1:0] dma_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_ctl_status_reg u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tc_pulse  (tc_pulse),
    .chan_go   (chan_go),
    .master_en (master_en),
    .dma_irq   (dma_irq)
  );

  // {wr, wdata, tc, exp_rdata, exp_irq, exp_go}
  localparam int NV = 9;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {1'b1, 8'h0C, 2'b00, 8'h3E, 2'b11, 2'b00},  // R7 R8: both gates open, enables 0, ie=11
    {1'b1, 8'h70, 2'b00, 8'h32, 2'b00, 2'b00},  // R3: gates closed, enable bits ignored
    {1'b1, 8'h60, 2'b00, 8'h73, 2'b00, 2'b01},  // R2 R5: ch0 on, master set
    {1'b1, 8'h9C, 2'b00, 8'hFF, 2'b00, 2'b11},  // R2 R3: ch1 on, ch0 gated off
    {1'b0, 8'h00, 2'b01, 8'hBF, 2'b01, 2'b10},  // R6 R8: tc clears ch0
    {1'b1, 8'h0C, 2'b00, 8'h3F, 2'b11, 2'b00},  // R5: writing 0 keeps master
    {1'b1, 8'hCC, 2'b10, 8'h7F, 2'b10, 2'b01},  // R6: tc beats write of 1 on ch1
    {1'b0, 8'h00, 2'b00, 8'h7F, 2'b10, 2'b01},  // R4: idle, reads unchanged
    {1'b1, 8'h34, 2'b00, 8'h77, 2'b00, 2'b01}   // R3 R7 R9: gates closed, ie=01
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic [1:0] tc);
    @(negedge clk);
    reg_wr    = wr;
    reg_wdata = wd;
    tc_pulse  = tc;
    @(posedge clk);
    #1;
    reg_wr   = 1'b0;
    tc_pulse = 2'b00;
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: state during reset
    chk("R1 rdata in reset", reg_rdata, 8'h32);
    chk("R1 master in reset", {7'd0, master_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 rdata after reset", reg_rdata, 8'h32);
    chk("R1 irq/go after reset", {4'd0, dma_irq, chan_go}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][22], VEC[k][21:14], VEC[k][13:12]);
      chk("R2/R3/R4/R5/R6/R7 vector rdata", reg_rdata, VEC[k][11:4]);
      chk("R8 vector irq", {6'd0, dma_irq}, {6'd0, VEC[k][3:2]});
      chk("R9 vector go", {6'd0, chan_go}, {6'd0, VEC[k][1:0]});
    end

    // R1: reset mid-run clears everything including master
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 async reset rdata", reg_rdata, 8'h32);
    chk("R1 async reset master", {7'd0, master_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: terminal count on idle channels leaves them off
    step(1'b0, 8'h00, 2'b11);
    chk("R6 tc on idle channels", reg_rdata, 8'h32);

    // R2 R5: ch0 on, ch1 written 0 with gate open
    step(1'b1, 8'h40, 2'b00);
    chk("R2 ch0 load", reg_rdata, 8'h73);
    chk("R9 ch0 go", {6'd0, chan_go}, 8'h01);

    // R5: turning every channel off keeps master set
    step(1'b1, 8'h00, 2'b00);
    chk("R5 master held after disable", reg_rdata, 8'h33);
    chk("R5 master output", {7'd0, master_en}, 8'h01);
    chk("R9 go after disable", {6'd0, chan_go}, 8'h00);

    // R5 R6: write 1 blocked by tc still sets master (after fresh reset)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 8'h80, 2'b10);
    chk("R6 ch1 blocked by tc", reg_rdata, 8'h33);
    chk("R5 master set despite tc", {7'd0, master_en}, 8'h01);

    done = 1'b1;
    summary();
  end

endmodule